// File: doc/BRIEF.md
# Error-Tolerant Sync Word Detector

This block hunts for a programmable sync word in a demodulated serial bit stream. Each received bit arrives with a one-cycle strobe. The detector keeps a history of the most recent bits and compares the newest N of them against the configured word, where N is 8, 16, 24 or 32. The comparison counts mismatching bit positions, and the word is accepted when that count is no larger than a programmable tolerance of 0 to 3. On acceptance it emits a one-cycle found pulse and stops searching. Every later bit is then forwarded as payload, with a marker on the first bit of each byte so that a byte assembler downstream can frame the data.

A stream that never carries the word within tolerance produces no pulse and no payload, so the frame is dropped without any notice. The detector searches again only after a re-arm pulse, which marks the end of a packet or a receiver restart, or after the enable has been cycled. Both of these also empty the bit history.

Top module: `sync_word_finder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `syncFound`, `payValid` and `payByteStart` are 0.
- R2: `sizeSel` selects N = 8 × (sizeSel + 1) bits (0→8, 1→16, 2→24, 3→32). The expected word is the top N bits of `syncValue`, and `syncValue[31]` is the first bit on the line. Bits below those N have no effect. When the N most recent strobed bits equal the word, `syncFound` is 1 in the cycle after the strobe that carried the last bit.
- R3: A candidate with up to `tolerance` mismatching bits is accepted. One with `tolerance`+1 mismatching bits is rejected.
- R4: No match is declared until at least N bits have been strobed since the search was armed.
- R5: After a match, each strobed bit appears on `payBit` with `payValid` = 1 in the cycle after its strobe. `payByteStart` is 1 on payload bits 0, 8, 16, … counted from the match.
- R6: After a match, no further `syncFound` occurs until re-armed. Sync patterns inside the payload are forwarded as data.
- R7: A `rearm` pulse returns the detector to searching with an empty bit history, so bits received before it cannot complete a match.
- R8: While `enable` is 0, strobed bits are ignored, and `syncFound` and `payValid` stay 0. Searching starts with an empty history two cycles after `enable` rises.
- R9: A stream that contains no acceptable word produces neither `syncFound` nor `payValid`.
- R10: `syncFound` is a single-cycle pulse for each match.
- R11: Cycles with `bitValid` = 0 do not shift the history or advance the payload, whatever `bitIn` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Turns sync recognition on |
| rearm | input | 1 | End-of-packet / restart pulse; resumes the search |
| bitValid | input | 1 | Strobe qualifying `bitIn` |
| bitIn | input | 1 | Demodulated received bit |
| syncValue | input | 32 | Sync word; bit 31 is sent first |
| sizeSel | input | 2 | Word length select (8/16/24/32 bits) |
| tolerance | input | 2 | Accepted bit-error count, 0 to 3 |
| syncFound | output | 1 | One-cycle pulse on detection |
| payValid | output | 1 | Payload bit strobe |
| payBit | output | 1 | Payload bit |
| payByteStart | output | 1 | Marks the first bit of each payload byte |

## Verification
The assertions watch properties that must hold in every cycle. `syncFound` never lasts longer than one cycle. It follows only an enabled strobe and never repeats while locked. Nothing leaves the block while it is disabled. Every payload bit follows a strobe, and every byte marker sits on a valid payload bit. The bench scenarios are needed for everything that depends on the data itself: the exact cycle of detection for each word length, the tolerance boundary (accepted at the limit, rejected one bit beyond it), the fill rule, the clearing of the history by re-arm and by disable, and the byte framing of the payload.

// File: rtl/sync_find_pkg.sv
package sync_find_pkg;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_HUNT,
    ST_LOCK
  } huntState_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic shiftEn;    // push the current bit into the history
    logic clearHist;  // forget all history
    logic lockStart;  // word accepted: restart byte framing
    logic payEn;      // forward the current bit as payload
  } dpCtrl_t;

endpackage

// File: rtl/sync_find_dp.sv
module sync_find_dp
  import sync_find_pkg::*;
#(
  parameter int SYNC_W = 32,
  parameter int LANE_W = 8,
  parameter int TOL_W  = 2,
  localparam int LANES = SYNC_W / LANE_W,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CNT_W = $clog2(SYNC_W + 1),
  localparam int IDX_W = (LANE_W > 1) ? $clog2(LANE_W) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic              bitIn,
  input  logic [SYNC_W-1:0] syncValue,
  input  logic [SEL_W-1:0]  sizeSel,
  input  logic [TOL_W-1:0]  tolerance,
  output logic              matchNow,
  output logic              payBit,
  output logic              payValid,
  output logic              payByteStart
);

  logic [SYNC_W-1:0] shiftReg;
  logic [CNT_W-1:0]  fillCnt;
  logic [IDX_W-1:0]  bitIdx;
  logic              payBitQ;
  logic              payValidQ;
  logic              payStartQ;

  logic [SYNC_W-1:0] candidate;
  logic [SYNC_W-1:0] expWord;
  logic [SYNC_W-1:0] laneMask;
  logic [SYNC_W-1:0] diffBits;
  logic [CNT_W-1:0]  nBits;
  logic [CNT_W-1:0]  shiftAmt;
  logic [CNT_W-1:0]  errCnt;
  logic [CNT_W:0]    fillPlusOne;
  logic              haveEnough;
  logic              withinTol;

  function automatic logic [CNT_W-1:0] countOnes(input logic [SYNC_W-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < SYNC_W; i++) begin
      c = c + CNT_W'(v[i]);
    end
    return c;
  endfunction

  // Word length in bits and alignment of the configured word.
  assign nBits    = CNT_W'((int'(sizeSel) + 1) * LANE_W);
  assign shiftAmt = CNT_W'(SYNC_W) - nBits;
  assign expWord  = syncValue >> shiftAmt;

  // Only the lanes covered by the selected length take part in the compare.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign laneMask[g*LANE_W +: LANE_W] = {LANE_W{(SEL_W'(g) <= sizeSel)}};
  end

  // Compare including the bit arriving now.
  assign candidate   = {shiftReg[SYNC_W-2:0], bitIn};
  assign diffBits    = (candidate ^ expWord) & laneMask;
  assign errCnt      = countOnes(diffBits);
  assign fillPlusOne = (CNT_W+1)'(fillCnt) + (CNT_W+1)'(1);
  assign haveEnough  = fillPlusOne >= (CNT_W+1)'(nBits);
  assign withinTol   = errCnt <= CNT_W'(tolerance);
  assign matchNow    = ctrl.shiftEn && haveEnough && withinTol;

  // Bit history and its fill level.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      fillCnt  <= '0;
    end else if (ctrl.clearHist) begin
      fillCnt <= '0;
    end else if (ctrl.shiftEn) begin
      shiftReg <= candidate;
      if (fillCnt < CNT_W'(SYNC_W)) begin
        fillCnt <= fillCnt + CNT_W'(1);
      end
    end
  end

  // Payload forwarding with byte framing.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitIdx    <= '0;
      payBitQ   <= 1'b0;
      payValidQ <= 1'b0;
      payStartQ <= 1'b0;
    end else begin
      payValidQ <= ctrl.payEn;
      payStartQ <= 1'b0;
      if (ctrl.lockStart) begin
        bitIdx <= '0;
      end else if (ctrl.payEn) begin
        payBitQ   <= bitIn;
        payStartQ <= (bitIdx == '0);
        bitIdx    <= (bitIdx == IDX_W'(LANE_W - 1)) ? '0 : bitIdx + IDX_W'(1);
      end
    end
  end

  assign payBit       = payBitQ;
  assign payValid     = payValidQ;
  assign payByteStart = payStartQ;

  a_r5_marker_on_valid: assert property (@(posedge clk) disable iff (!rstN)
    payByteStart |-> payValid);

  a_r4_fill_in_range: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= CNT_W'(SYNC_W));

endmodule

// File: rtl/sync_find_ctrl.sv
module sync_find_ctrl
  import sync_find_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    rearm,
  input  logic    bitValid,
  input  logic    matchNow,
  output dpCtrl_t dpCtrl,
  output logic    syncFound
);

  huntState_t state;
  huntState_t stateNext;
  logic       syncFoundQ;
  logic       active;

  assign active = enable && !rearm;

  always_comb begin
    stateNext = state;
    if (!enable) begin
      stateNext = ST_OFF;
    end else if (rearm) begin
      stateNext = ST_HUNT;
    end else begin
      unique case (state)
        ST_OFF:  stateNext = ST_HUNT;
        ST_HUNT: if (matchNow) stateNext = ST_LOCK;
        ST_LOCK: stateNext = ST_LOCK;
        default: stateNext = ST_OFF;
      endcase
    end
  end

  always_comb begin
    dpCtrl.shiftEn   = (state == ST_HUNT) && bitValid && active;
    dpCtrl.clearHist = (state != ST_HUNT) || !active;
    dpCtrl.lockStart = (state == ST_HUNT) && matchNow;
    dpCtrl.payEn     = (state == ST_LOCK) && bitValid && active;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_OFF;
      syncFoundQ <= 1'b0;
    end else begin
      state      <= stateNext;
      syncFoundQ <= dpCtrl.lockStart;
    end
  end

  assign syncFound = syncFoundQ;

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    syncFoundQ |=> !syncFoundQ);

  a_r6_no_refind: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCK && enable && !rearm) |=> !syncFoundQ);

endmodule

// File: rtl/sync_word_finder.sv
module sync_word_finder
  import sync_find_pkg::*;
#(
  parameter int SYNC_W = 32,
  parameter int LANE_W = 8,
  parameter int TOL_W  = 2,
  localparam int LANES = SYNC_W / LANE_W,
  localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              rearm,
  input  logic              bitValid,
  input  logic              bitIn,
  input  logic [SYNC_W-1:0] syncValue,
  input  logic [SEL_W-1:0]  sizeSel,
  input  logic [TOL_W-1:0]  tolerance,
  output logic              syncFound,
  output logic              payValid,
  output logic              payBit,
  output logic              payByteStart
);

  dpCtrl_t dpCtrl;
  logic    matchNow;

  sync_find_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .rearm     (rearm),
    .bitValid  (bitValid),
    .matchNow  (matchNow),
    .dpCtrl    (dpCtrl),
    .syncFound (syncFound)
  );

  sync_find_dp #(
    .SYNC_W (SYNC_W),
    .LANE_W (LANE_W),
    .TOL_W  (TOL_W)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (dpCtrl),
    .bitIn        (bitIn),
    .syncValue    (syncValue),
    .sizeSel      (sizeSel),
    .tolerance    (tolerance),
    .matchNow     (matchNow),
    .payBit       (payBit),
    .payValid     (payValid),
    .payByteStart (payByteStart)
  );

  a_r2_found_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    syncFound |-> $past(bitValid && enable));

  a_r5_pay_follows_strobe: assert property (@(posedge clk) disable iff (!rstN)
    payValid |-> $past(bitValid));

  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!syncFound && !payValid));

endmodule

// File: tb/test_sync_word_finder.sv
module test_sync_word_finder;

  localparam int CLK_PERIOD = 10;
  localparam int SYNC_CODE  = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic        rearm = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic [31:0] syncValue = '0;
  logic [1:0]  sizeSel = '0;
  logic [1:0]  tolerance = '0;
  logic        syncFound;
  logic        payValid;
  logic        payBit;
  logic        payByteStart;

  int checks = 0;
  int errors = 0;
  int unexpected = 0;
  int quietMark = 0;
  int payCount = 0;
  bit done = 1'b0;

  int    expCode[$];
  string expTag[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sync_word_finder i_sync_word_finder (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .rearm        (rearm),
    .bitValid     (bitValid),
    .bitIn        (bitIn),
    .syncValue    (syncValue),
    .sizeSel      (sizeSel),
    .tolerance    (tolerance),
    .syncFound    (syncFound),
    .payValid     (payValid),
    .payBit       (payBit),
    .payByteStart (payByteStart)
  );

  // Scoreboard compare: codes 0..3 = {byteStart, bit}, 4 = sync pulse.
  task automatic observe(input int got);
    checks++;
    if (expCode.size() == 0) begin
      errors++;
      unexpected++;
      $display("FAIL R9/R6/R10: unexpected output code %0d, expected none", got);
    end else begin
      int    want;
      string tag;
      want = expCode.pop_front();
      tag  = expTag.pop_front();
      if (got != want) begin
        errors++;
        $display("FAIL %s: output code %0d, expected %0d", tag, got, want);
      end
    end
  endtask

  // Monitor samples away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (syncFound) observe(SYNC_CODE);
      if (payValid) observe({30'd0, payByteStart, payBit});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a falling edge; drives one strobed bit.
  task automatic sendBit(input logic b);
    bitValid = 1'b1;
    bitIn    = b;
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic sendBits(input logic [31:0] v, input int n, input bit expectSync,
                          input string tag, input int gap);
    for (int i = n - 1; i >= 0; i--) begin
      if (expectSync && i == 0) begin
        expCode.push_back(SYNC_CODE);
        expTag.push_back(tag);
        payCount = 0;
      end
      sendBit(v[i]);
      if (gap > 0) begin
        bitIn = ~v[i];
        idle(gap);
      end
    end
  endtask

  task automatic sendPayload(input logic [31:0] v, input int n, input string tag,
                             input int gap);
    for (int i = n - 1; i >= 0; i--) begin
      expCode.push_back({30'd0, (payCount % 8 == 0), v[i]});
      expTag.push_back(tag);
      payCount++;
      sendBit(v[i]);
      if (gap > 0) begin
        bitIn = ~v[i];
        idle(gap);
      end
    end
  endtask

  task automatic pulseRearm();
    rearm = 1'b1;
    @(negedge clk);
    rearm = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [1:0] t, input logic [31:0] w);
    sizeSel   = s;
    tolerance = t;
    syncValue = w;
  endtask

  // All expected outputs seen and nothing extra since the last settle point.
  task automatic checkSettled(input string tag);
    idle(3);
    checks++;
    if (unexpected != quietMark || expCode.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d unexpected outputs and %0d missing, expected 0 and 0",
               tag, unexpected - quietMark, expCode.size());
    end
    quietMark = unexpected;
    expCode.delete();
    expTag.delete();
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finishRun();
    end
  end

  initial begin
    // R1: outputs quiet in reset and just after it
    idle(3);
    checks++;
    if (syncFound || payValid || payByteStart) begin
      errors++;
      $display("FAIL R1: outputs %b%b%b in reset, expected 000", syncFound, payValid, payByteStart);
    end
    rstN = 1'b1;
    idle(1);
    checks++;
    if (syncFound || payValid || payByteStart) begin
      errors++;
      $display("FAIL R1: outputs %b%b%b after reset, expected 000", syncFound, payValid, payByteStart);
    end

    // R2 / R5 / R6: 16-bit word after preamble, then framed payload
    cfg(2'd1, 2'd0, 32'hB3C5_0000);
    enable = 1'b1;
    idle(2);
    sendBits(32'h55, 8, 1'b0, "R2", 0);
    sendBits(32'hB3C5, 16, 1'b1, "R2", 0);
    sendPayload(32'hA7, 8, "R5", 0);
    sendPayload(32'h3C, 8, "R5", 0);
    sendPayload(32'hB3C5, 16, "R6", 0);
    checkSettled("R6");

    // R7: history split by rearm cannot match; full word afterwards does
    pulseRearm();
    sendBits(32'hB3, 8, 1'b0, "R7", 0);
    pulseRearm();
    sendBits(32'hC5, 8, 1'b0, "R7", 0);
    checkSettled("R7");
    sendBits(32'hB3C5, 16, 1'b1, "R7", 0);
    checkSettled("R7");

    // R3 / R10: 32-bit word, tolerance 2, two flips accepted, single pulse
    cfg(2'd3, 2'd2, 32'h1D2E_3F40);
    pulseRearm();
    sendBits(32'h1D2E_3F40 ^ 32'h0001_0080, 32, 1'b1, "R10", 0);
    sendPayload(32'h5A, 8, "R5", 0);
    checkSettled("R10");
    // R3: three flips rejected at tolerance 2
    pulseRearm();
    sendBits(32'h1D2E_3F40 ^ 32'h8001_0080, 32, 1'b0, "R3", 0);
    checkSettled("R3");

    // R3 / R2: 8-bit word, tolerance 3, three flips accepted, low bytes ignored
    cfg(2'd0, 2'd3, 32'h1DFF_FFFF);
    pulseRearm();
    sendBits(32'h1D ^ 32'h83, 8, 1'b1, "R3", 0);
    sendPayload(32'hF0, 8, "R5", 0);
    checkSettled("R2");
    // R3: one flip rejected at tolerance 0
    cfg(2'd0, 2'd0, 32'h1DFF_FFFF);
    pulseRearm();
    sendBits(32'h1D ^ 32'h10, 8, 1'b0, "R3", 0);
    checkSettled("R3");

    // R4: all-zero 24-bit word; 23 zeros are not enough, the 24th is
    cfg(2'd2, 2'd0, 32'h0000_00AB);
    pulseRearm();
    sendBits(32'h0, 23, 1'b0, "R4", 0);
    checkSettled("R4");
    sendBits(32'h0, 1, 1'b1, "R4", 0);
    checkSettled("R4");

    // R11: strobes with gaps and garbage on bitIn between them
    cfg(2'd1, 2'd0, 32'hB3C5_0000);
    pulseRearm();
    sendBits(32'hB3C5, 16, 1'b1, "R11", 2);
    sendPayload(32'h96, 8, "R11", 1);
    checkSettled("R11");

    // R8: disabled input is ignored; search restarts after enable
    enable = 1'b0;
    idle(2);
    sendBits(32'hB3C5, 16, 1'b0, "R8", 0);
    sendBits(32'hAA, 8, 1'b0, "R8", 0);
    checkSettled("R8");
    enable = 1'b1;
    idle(2);
    sendBits(32'hB3C5, 16, 1'b1, "R8", 0);
    sendPayload(32'h01, 8, "R8", 0);
    checkSettled("R8");

    // R9: stream without the word is dropped silently
    cfg(2'd3, 2'd0, 32'h1D2E_3F40);
    pulseRearm();
    sendBits(32'hFFFF_FFFF, 32, 1'b0, "R9", 0);
    sendBits(32'h0F0F_0F0F, 32, 1'b0, "R9", 0);
    checkSettled("R9");

    finishRun();
  end

endmodule